// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

The block merges a 64x64 two-plane monochrome cursor into a stream of display pixels. Each incoming pixel carries its beam coordinates and background value. The block compares those coordinates with the cursor window and clips the window at the active display edges. For each cursor pixel it then leaves the background alone, inverts it, or replaces it with one of two programmable 24-bit colours.

Cursor pattern rows are held in an external byte-wide pattern RAM that has one cycle of read latency. During horizontal blanking the controller pulses `prep_go` with the y coordinate of the next line. The block then reads that line's 16 pattern bytes into a local line buffer, and pixel streaming for that line starts after `prefetch_busy` drops. A small register write port sets the base address, position, hotspot offset and colours. These values are held as pending copies. They move into the active copies only at a `frame_start` pulse, and only while the lock bit is clear.

Pixels enter and leave through valid/ready streams. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output beat transfers where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_pix` and `out_valid` hold. `in_ready` drops only when both pipeline stages are full and the output is stalled.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `prefetch_busy` and `pat_rd_en` are 0, and every active register is zero: position (0,0), base 0, hotspot 0, both colours 0.
- R2: A cursor line occupies 16 consecutive pattern bytes. Bytes 0-7 are the AND plane and bytes 8-15 the XOR plane. Byte k covers cursor columns 8k..8k+7, with the most significant bit first.
- R3: A pixel with AND=1 and XOR=1 outputs the bitwise complement of the 32-bit background.
- R4: A pixel with AND=1 and XOR=0 outputs the background unchanged.
- R5: A pixel with AND=0 outputs {colour, 8'hFF}, using colour 1 when XOR=1 and colour 0 when XOR=0. Colour writes keep data bits 23:0 only.
- R6: Selector 1 writes the position: x from data bits 29:16 and y from bits 13:0. The cursor covers columns x..x+63 and lines y..y+63, and pixels outside that window pass through.
- R7: Selector 2 writes the hotspot: x offset from bits 21:16 and y offset from bits 5:0. Selector 0 writes the base address from bits 11:4. The first pattern address of cursor row 0 is base*16 - xoff - 16*yoff, modulo the pattern RAM size.
- R8: No cursor pixel is drawn at any x at or beyond (h_disp+1)*8.
- R9: Lines with y greater than `v_disp` pass through. While `cur_en` is 0, every pixel passes through.
- R10: Data bit 31 of a base, position or hotspot write sets the lock when 1 and clears it when 0. While the lock is set, `frame_start` leaves the active copies unchanged.
- R11: Active copies change only on a `frame_start` with the lock clear. Writes between frame starts do not affect the displayed cursor.
- R12: The stream has a fixed latency of two cycles when not stalled, and a stalled output holds its value. Selectors 3 and 4 write colour 0 and colour 1.
- R13: A `prep_go` while idle issues 16 reads on consecutive cycles. The read addresses are start + 16*((prep_y - y) mod 64) + k for k = 0..15. `prefetch_busy` stays high for 17 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 base, 1 position, 2 hotspot, 3 colour 0, 4 colour 1 |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Start of frame; commits pending values when unlocked |
| cur_en | input | 1 | Cursor enable |
| h_disp | input | 11 | Horizontal display field; active width is (h_disp+1)*8 |
| v_disp | input | 12 | Last visible line |
| prep_go | input | 1 | Start the prefetch of one cursor line |
| prep_y | input | 14 | Line to prefetch |
| prefetch_busy | output | 1 | Prefetch in progress |
| pat_rd_en | output | 1 | Pattern RAM read enable |
| pat_addr | output | 12 | Pattern RAM byte address |
| pat_rdata | input | 8 | Pattern RAM data, one cycle after the read |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_x | input | 14 | Beam x of the input pixel |
| in_y | input | 14 | Beam y of the input pixel |
| in_bg | input | 32 | Background pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_pix | output | 32 | Merged pixel |

## Verification
The pattern RAM holds a pseudo-random byte image, so streamed lines cross all four AND/XOR combinations many times. A mismatch therefore identifies the plane order, the bit order or the mode decode that went wrong. Lines are streamed above, inside and below the window, across its left and right edges, and with a narrow display width and a short display height. This separates window tests from the display clipping rules. A non-zero hotspot gives misaligned start addresses, which exposes any subtraction or row-scaling error. A lock sequence with writes between frame starts shows whether values commit early, and a phase with random `out_ready` tests how the output holds under back-pressure.

// File: rtl/curs_pkg.sv
package curs_pkg;
  localparam int CUR_DIM     = 64;
  localparam int LINE_BYTES  = 16;
  localparam int PLANE_BYTES = LINE_BYTES / 2;
  localparam int PIX_W       = 32;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_POS  = 3'd1,
    SEL_HOT  = 3'd2,
    SEL_COL0 = 3'd3,
    SEL_COL1 = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    PM_PASS,
    PM_INV,
    PM_COL0,
    PM_COL1
  } pix_mode_e;

  function automatic pix_mode_e pick_mode(logic hit, logic and_b, logic xor_b);
    if (!hit) return PM_PASS;
    if (and_b) return xor_b ? PM_INV : PM_PASS;
    return xor_b ? PM_COL1 : PM_COL0;
  endfunction
endpackage

// File: rtl/curs_regs.sv
module curs_regs
  import curs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int POS_W  = 14,
  parameter int COL_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              frame_start,
  output logic [POS_W-1:0]  act_x,
  output logic [POS_W-1:0]  act_y,
  output logic [COL_W-1:0]  act_col0,
  output logic [COL_W-1:0]  act_col1,
  output logic [ADDR_W-1:0] act_start
);
  localparam int SH_W   = $clog2(LINE_BYTES);
  localparam int BASE_W = ADDR_W - SH_W;
  localparam int HOT_W  = 6;

  logic [BASE_W-1:0] pend_base, act_base;
  logic [POS_W-1:0]  pend_x, pend_y;
  logic [HOT_W-1:0]  pend_hx, pend_hy, act_hx, act_hy;
  logic [COL_W-1:0]  pend_c0, pend_c1;
  logic              lock_q;
  logic              unused_wr_bits;

  assign unused_wr_bits = wr_data[30];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_base <= '0;
      pend_x    <= '0;
      pend_y    <= '0;
      pend_hx   <= '0;
      pend_hy   <= '0;
      pend_c0   <= '0;
      pend_c1   <= '0;
      lock_q    <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_BASE: begin
          pend_base <= wr_data[ADDR_W-1:SH_W];
          lock_q    <= wr_data[31];
        end
        SEL_POS: begin
          pend_x <= wr_data[16 +: POS_W];
          pend_y <= wr_data[POS_W-1:0];
          lock_q <= wr_data[31];
        end
        SEL_HOT: begin
          pend_hx <= wr_data[16 +: HOT_W];
          pend_hy <= wr_data[HOT_W-1:0];
          lock_q  <= wr_data[31];
        end
        SEL_COL0: pend_c0 <= wr_data[COL_W-1:0];
        SEL_COL1: pend_c1 <= wr_data[COL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_base <= '0;
      act_x    <= '0;
      act_y    <= '0;
      act_hx   <= '0;
      act_hy   <= '0;
      act_col0 <= '0;
      act_col1 <= '0;
    end else if (frame_start && !lock_q) begin
      act_base <= pend_base;
      act_x    <= pend_x;
      act_y    <= pend_y;
      act_hx   <= pend_hx;
      act_hy   <= pend_hy;
      act_col0 <= pend_c0;
      act_col1 <= pend_c1;
    end
  end

  assign act_start = {act_base, {SH_W{1'b0}}} - ADDR_W'(act_hx)
                   - ADDR_W'({act_hy, {SH_W{1'b0}}});

  a_r10_frozen_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(act_x) && $stable(act_y) && $stable(act_col0) && $stable(act_start));

  a_r11_change_only_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_x) && $stable(act_col1) && $stable(act_start));
endmodule

// File: rtl/curs_fetch.sv
module curs_fetch
  import curs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int POS_W  = 14,
  parameter int VD_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [POS_W-1:0]   prep_y,
  input  logic [POS_W-1:0]   act_y,
  input  logic [ADDR_W-1:0]  act_start,
  input  logic [VD_W-1:0]    v_disp,
  output logic               busy,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [7:0]         rd_data,
  output logic [CUR_DIM-1:0] and_plane,
  output logic [CUR_DIM-1:0] xor_plane,
  output logic               line_hit,
  output logic [POS_W-1:0]   line_y
);
  localparam int CNT_W = $clog2(LINE_BYTES);
  localparam int ROW_W = $clog2(CUR_DIM);
  localparam int CW    = (POS_W > VD_W ? POS_W : VD_W) + 1;

  logic              fetching, rd_q;
  logic [CNT_W-1:0]  cnt, idx_q;
  logic [ADDR_W-1:0] row_base_q;
  logic [7:0]        line_q [LINE_BYTES];
  logic [POS_W-1:0]  row;
  logic              in_rows, in_disp;

  assign row     = prep_y - act_y;
  assign in_rows = (prep_y >= act_y) && (row < POS_W'(CUR_DIM));
  assign in_disp = CW'(prep_y) <= CW'(v_disp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching   <= 1'b0;
      cnt        <= '0;
      row_base_q <= '0;
      line_hit   <= 1'b0;
      line_y     <= '0;
    end else if (go && !busy) begin
      fetching   <= 1'b1;
      cnt        <= '0;
      row_base_q <= act_start + ADDR_W'({row[ROW_W-1:0], {CNT_W{1'b0}}});
      line_hit   <= in_rows && in_disp;
      line_y     <= prep_y;
    end else if (fetching) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(LINE_BYTES - 1)) fetching <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      rd_q  <= fetching;
      idx_q <= cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINE_BYTES; i++) line_q[i] <= '0;
    end else if (rd_q) begin
      line_q[idx_q] <= rd_data;
    end
  end

  assign busy    = fetching | rd_q;
  assign rd_en   = fetching;
  assign rd_addr = row_base_q + ADDR_W'(cnt);

  for (genvar c = 0; c < CUR_DIM; c++) begin : g_unpack
    assign and_plane[c] = line_q[c / 8][7 - (c % 8)];
    assign xor_plane[c] = line_q[PLANE_BYTES + c / 8][7 - (c % 8)];
  end

  a_r13_go_starts_reads: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy |=> rd_en && busy);

  a_r13_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));
endmodule

// File: rtl/curs_pixel.sv
module curs_pixel
  import curs_pkg::*;
#(
  parameter int POS_W = 14,
  parameter int HD_W  = 11,
  parameter int COL_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cur_en,
  input  logic [HD_W-1:0]    h_disp,
  input  logic [POS_W-1:0]   act_x,
  input  logic [COL_W-1:0]   act_col0,
  input  logic [COL_W-1:0]   act_col1,
  input  logic [CUR_DIM-1:0] and_plane,
  input  logic [CUR_DIM-1:0] xor_plane,
  input  logic               line_hit,
  input  logic [POS_W-1:0]   line_y,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [POS_W-1:0]   in_x,
  input  logic [POS_W-1:0]   in_y,
  input  logic [PIX_W-1:0]   in_bg,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_pix
);
  localparam int ROW_W = $clog2(CUR_DIM);
  localparam int CW    = (POS_W > HD_W + 3 ? POS_W : HD_W + 3) + 1;
  localparam int PAD_W = PIX_W - COL_W;

  logic [CW-1:0]    wid;
  logic [POS_W-1:0] dx;
  logic [ROW_W-1:0] col;
  logic             draw;

  logic             v1, hit1, and1, xor1;
  logic [PIX_W-1:0] bg1;
  logic             v2;
  logic [PIX_W-1:0] pix2, nxt_pix;
  pix_mode_e        mode1;

  assign wid  = (CW'(h_disp) + CW'(1)) << 3;
  assign dx   = in_x - act_x;
  assign col  = dx[ROW_W-1:0];
  assign draw = cur_en && line_hit && (in_y == line_y) && (in_x >= act_x)
             && (dx < POS_W'(CUR_DIM)) && (CW'(in_x) < wid);

  assign in_ready = !v1 || !v2 || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      hit1 <= 1'b0;
      and1 <= 1'b0;
      xor1 <= 1'b0;
      bg1  <= '0;
    end else if (in_ready) begin
      v1 <= in_valid;
      if (in_valid) begin
        hit1 <= draw;
        and1 <= and_plane[col];
        xor1 <= xor_plane[col];
        bg1  <= in_bg;
      end
    end
  end

  assign mode1 = pick_mode(hit1, and1, xor1);

  always_comb begin
    case (mode1)
      PM_INV:  nxt_pix = ~bg1;
      PM_COL0: nxt_pix = {act_col0, {PAD_W{1'b1}}};
      PM_COL1: nxt_pix = {act_col1, {PAD_W{1'b1}}};
      default: nxt_pix = bg1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      pix2 <= '0;
    end else if (!v2 || out_ready) begin
      v2 <= v1;
      if (v1) pix2 <= nxt_pix;
    end
  end

  assign out_valid = v2;
  assign out_pix   = pix2;

  a_r12_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  a_r12_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> v1);
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import curs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int POS_W  = 14,
  parameter int HD_W   = 11,
  parameter int VD_W   = 12,
  parameter int COL_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              frame_start,
  input  logic              cur_en,
  input  logic [HD_W-1:0]   h_disp,
  input  logic [VD_W-1:0]   v_disp,
  input  logic              prep_go,
  input  logic [POS_W-1:0]  prep_y,
  output logic              prefetch_busy,
  output logic              pat_rd_en,
  output logic [ADDR_W-1:0] pat_addr,
  input  logic [7:0]        pat_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [POS_W-1:0]  in_x,
  input  logic [POS_W-1:0]  in_y,
  input  logic [31:0]       in_bg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_pix
);
  logic [POS_W-1:0]   act_x, act_y, line_y;
  logic [COL_W-1:0]   act_col0, act_col1;
  logic [ADDR_W-1:0]  act_start;
  logic [CUR_DIM-1:0] and_plane, xor_plane;
  logic               line_hit;

  curs_regs #(.ADDR_W(ADDR_W), .POS_W(POS_W), .COL_W(COL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .frame_start(frame_start), .act_x(act_x), .act_y(act_y),
    .act_col0(act_col0), .act_col1(act_col1), .act_start(act_start)
  );

  curs_fetch #(.ADDR_W(ADDR_W), .POS_W(POS_W), .VD_W(VD_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(prep_go), .prep_y(prep_y), .act_y(act_y),
    .act_start(act_start), .v_disp(v_disp), .busy(prefetch_busy),
    .rd_en(pat_rd_en), .rd_addr(pat_addr), .rd_data(pat_rdata),
    .and_plane(and_plane), .xor_plane(xor_plane),
    .line_hit(line_hit), .line_y(line_y)
  );

  curs_pixel #(.POS_W(POS_W), .HD_W(HD_W), .COL_W(COL_W)) u_pixel (
    .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .h_disp(h_disp),
    .act_x(act_x), .act_col0(act_col0), .act_col1(act_col1),
    .and_plane(and_plane), .xor_plane(xor_plane),
    .line_hit(line_hit), .line_y(line_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_bg(in_bg),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );
endmodule

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
  localparam int ADDR_W = 12, POS_W = 14, HD_W = 11, VD_W = 12;
  localparam int NB = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [2:0] wr_sel = '0; logic [31:0] wr_data = '0;
  logic frame_start = 1'b0, cur_en = 1'b1;
  logic [HD_W-1:0] h_disp = 11'd79; logic [VD_W-1:0] v_disp = 12'd479;
  logic prep_go = 1'b0; logic [POS_W-1:0] prep_y = '0;
  logic prefetch_busy, pat_rd_en; logic [ADDR_W-1:0] pat_addr; logic [7:0] pat_rdata = '0;
  logic in_valid = 1'b0, in_ready; logic [POS_W-1:0] in_x = '0, in_y = '0; logic [31:0] in_bg = '0;
  logic out_valid, out_ready = 1'b1; logic [31:0] out_pix;

  cursor_overlay dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .frame_start(frame_start), .cur_en(cur_en), .h_disp(h_disp), .v_disp(v_disp),
    .prep_go(prep_go), .prep_y(prep_y), .prefetch_busy(prefetch_busy),
    .pat_rd_en(pat_rd_en), .pat_addr(pat_addr), .pat_rdata(pat_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_bg(in_bg),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  always #2 clk = ~clk;

  logic [7:0] pat_mem [NB];
  initial for (int i = 0; i < NB; i++) pat_mem[i] = 8'((i * 73) ^ ((i >> 3) * 29) ^ 8'h5A);
  always @(posedge clk) if (pat_rd_en) pat_rdata <= pat_mem[pat_addr];

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, lat_chk = 1;
  string cur_tag = "R1";
  // model state: pending and active copies
  int m_base = 0, m_x = 0, m_y = 0, m_hx = 0, m_hy = 0, m_c0 = 0, m_c1 = 0; bit m_lock = 0;
  int a_base = 0, a_x = 0, a_y = 0, a_hx = 0, a_hy = 0, a_c0 = 0, a_c1 = 0;
  int f_base = 0, f_k = 0;
  logic [31:0] exp_q[$]; int cyc_q[$]; string tag_q[$];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_start();
    return (a_base * 16 - a_hx - 16 * a_hy) & (NB - 1);
  endfunction

  function automatic logic [31:0] model_pix(int x, int y, logic [31:0] bg, output string tag);
    int addr, col; bit a, xb;
    if (!cur_en || y > int'(v_disp)) begin tag = "R9"; return bg; end
    if (y < a_y || y >= a_y + 64 || x < a_x || x >= a_x + 64) begin tag = "R6"; return bg; end
    if (x >= (int'(h_disp) + 1) * 8) begin tag = "R8"; return bg; end
    col  = x - a_x;
    addr = m_start() + (y - a_y) * 16 + col / 8;   // R2 plane/byte layout
    a  = pat_mem[addr & (NB - 1)][7 - col % 8];
    xb = pat_mem[(addr + 8) & (NB - 1)][7 - col % 8];
    if (a && xb) begin tag = "R3"; return ~bg; end
    if (a) begin tag = "R4"; return bg; end
    tag = "R5";
    return {24'(xb ? a_c1 : a_c0), 8'hFF};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL R12 watchdog expired actual=%0d expected<%0d", cyc, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (wr_en) begin
        case (wr_sel)
          3'd0: begin m_base = int'(wr_data[11:4]); m_lock = wr_data[31]; end
          3'd1: begin m_x = int'(wr_data[29:16]); m_y = int'(wr_data[13:0]); m_lock = wr_data[31]; end
          3'd2: begin m_hx = int'(wr_data[21:16]); m_hy = int'(wr_data[5:0]); m_lock = wr_data[31]; end
          3'd3: m_c0 = int'(wr_data[23:0]);
          3'd4: m_c1 = int'(wr_data[23:0]);
          default: ;
        endcase
      end
      if (frame_start && !m_lock) begin
        a_base = m_base; a_x = m_x; a_y = m_y; a_hx = m_hx; a_hy = m_hy; a_c0 = m_c0; a_c1 = m_c1;
      end
      if (prep_go && !prefetch_busy) begin
        f_k = 0;
        f_base = m_start() + ((int'(prep_y) - a_y) & 63) * 16;
      end
      if (pat_rd_en) begin
        check(int'(pat_addr) == ((f_base + f_k) & (NB - 1)), "R13 read address",
              32'(pat_addr), 32'((f_base + f_k) & (NB - 1)));
        f_k++;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R12 unexpected output", out_pix, 32'hx);
        else begin
          logic [31:0] e; int c; string t;
          e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
          check(out_pix === e, {cur_tag, "/", t, " pixel"}, out_pix, e);
          if (lat_chk) check(cyc - c == 2, "R12 latency", 32'(cyc - c), 32'd2);
        end
      end
      if (in_valid && in_ready) begin
        string t;
        exp_q.push_back(model_pix(int'(in_x), int'(in_y), in_bg, t));
        cyc_q.push_back(cyc); tag_q.push_back(t);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step();
    @(posedge clk); #0.5;
  endtask

  task automatic write_reg(logic [2:0] sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic new_frame();
    frame_start = 1'b1; step(); frame_start = 1'b0;
  endtask

  task automatic fetch_line(int y);
    int n = 0;
    prep_y = POS_W'(y); prep_go = 1'b1; step(); prep_go = 1'b0;
    while (prefetch_busy && n < 100) begin n++; step(); end
    check(n == 17, "R13 busy cycles", 32'(n), 32'd17);
  endtask

  task automatic stream_line(int y, int x0, int x1, bit stall);
    bit acc;
    lat_chk = !stall;
    for (int x = x0; x <= x1; x++) begin
      in_valid = 1'b1; in_x = POS_W'(x); in_y = POS_W'(y);
      in_bg = {8'(x), 8'(y * 3), 16'(x * 257 + y)};
      do begin
        out_ready = stall ? 1'($urandom % 2) : 1'b1;
        #0.5; acc = in_ready;
        @(posedge clk); #0.5;
      end while (!acc);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) step();
    check(exp_q.size() == 0, "R12 drain", 32'(exp_q.size()), 32'd0);
    step(); lat_chk = 1;
  endtask

  task automatic line(int y, int x0, int x1);
    fetch_line(y); stream_line(y, x0, x1, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #0.5; rst_n = 1'b1; step();
    // R1 reset state
    check(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
    check(in_ready == 1, "R1 in_ready", 32'(in_ready), 1);
    check(prefetch_busy == 0 && pat_rd_en == 0, "R1 fetch idle", 32'(prefetch_busy), 0);
    cur_tag = "R1"; line(0, 0, 70);                // zero active regs: cursor at origin
    // R2 R3 R4 R5 R6: basic window and colours
    cur_tag = "R6";
    write_reg(3'd0, 32'h0000_0100);
    write_reg(3'd1, (32'd10 << 16) | 32'd5);
    write_reg(3'd3, 32'hAB12_3456);                // R5 upper byte dropped
    write_reg(3'd4, 32'h00FE_DCBA);
    new_frame();
    line(4, 0, 80); line(5, 0, 80); line(6, 0, 80);
    line(37, 0, 80); line(68, 0, 80); line(69, 0, 80);
    // R7 hotspot offset
    cur_tag = "R7";
    write_reg(3'd2, (32'd3 << 16) | 32'd2);
    new_frame();
    line(6, 0, 80); line(40, 0, 80);
    // R8 right-edge clip at (8+1)*8 = 72
    cur_tag = "R8";
    h_disp = 11'd8; line(10, 60, 80); h_disp = 11'd79;
    // R9 vertical end and enable
    cur_tag = "R9";
    v_disp = 12'd6; line(6, 0, 80); line(7, 0, 80); v_disp = 12'd479;
    cur_en = 1'b0; line(6, 0, 80); cur_en = 1'b1;
    // R10 lock via position bit 31
    cur_tag = "R10";
    write_reg(3'd1, 32'h8000_0000 | (32'd30 << 16) | 32'd20);
    new_frame();
    line(70, 0, 100); line(6, 0, 80);
    // R11 unlock commits only at the next frame
    cur_tag = "R11";
    write_reg(3'd2, 32'h0000_0000);
    line(70, 0, 100);
    new_frame();
    line(70, 0, 100);
    // R12 back-pressure
    cur_tag = "R12";
    fetch_line(40); stream_line(40, 0, 100, 1);
    finish_run();
  end
endmodule